// File: doc/BRIEF.md
# NRZ to Manchester Line Encoder

This block converts a serial NRZ bit stream into a Manchester line signal. It runs on a clock at twice the bit rate, so each NRZ bit is seen on two consecutive fast-clock cycles. A 0 bit goes out as a low half followed by a high half, which gives a rising edge at mid-bit. A 1 bit goes out as a high half followed by a low half, which gives a falling edge at mid-bit.

The encoder is a three-phase machine. It leaves its start phase on the first half of every bit and always returns to it one cycle later. An input change during the second half of a bit cannot occur on a well-formed stream. The block ignores such a change: the line level for the second half depends only on the bit taken in the first half. A parameter selects the output form. The default form drives the line straight from the phase and the input, so the first half follows the input in the same cycle. In this form a late input edge can cause a glitch. The registered form places one flop on the outputs, which removes the glitch and delays the line by one fast-clock cycle. A bit-first flag marks the first half of each bit.

Top module: `nrz_manchester_enc`

## Requirements
- R1: For a 0 bit, `line_out` is 0 in the first half and 1 in the second half. This is the unregistered timing.
- R2: For a 1 bit, `line_out` is 1 in the first half and 0 in the second half. This is the unregistered timing.
- R3: `bit_first` is 1 in the first half of each bit and 0 in the second half. It alternates on every cycle, starting with 1 in the first cycle after reset.
- R4: The value of `nrz_in` during a second half has no effect. That half's level is the inverse of the bit sampled in the first half, and the following cycle is again a first half.
- R5: With `REGISTERED_OUT=0`, `line_out` equals `nrz_in` in the same cycle during the first half.
- R6: With `REGISTERED_OUT=1`, `line_out` and `bit_first` carry the unregistered values of the previous cycle.
- R7: A synchronous active-high `rst` returns the encoder to the start phase, including in mid-bit. The first cycle after reset is a first half. With `REGISTERED_OUT=1`, both outputs read 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twice the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| nrz_in | input | 1 | NRZ data, held for two clock cycles per bit |
| line_out | output | 1 | Manchester-coded line |
| bit_first | output | 1 | High during the first half of each bit |

## Verification
The assertions assume that `nrz_in` is stable across each clock edge. They do not assume the two halves of a bit agree, because R4 covers the case where they differ. The bench changes the input only at the falling clock edge. It mostly sends clean two-cycle bits, and in a second group it deliberately flips the input during the second half. Resets are placed both on bit boundaries and in the middle of a bit, so the start-phase rule is checked from both positions.

// File: rtl/manch_pkg.sv
package manch_pkg;

    typedef enum logic [1:0] {
        PH_START   = 2'd0,
        PH_TAIL_HI = 2'd1,
        PH_TAIL_LO = 2'd2
    } phase_e;

    typedef struct packed {
        logic level;
        logic first;
    } sym_t;

    function automatic phase_e next_phase(input phase_e cur, input logic x);
        phase_e n;
        case (cur)
            PH_START: n = x ? PH_TAIL_LO : PH_TAIL_HI;
            default:  n = PH_START;
        endcase
        return n;
    endfunction

    function automatic sym_t symbol_of(input phase_e cur, input logic x);
        sym_t s;
        case (cur)
            PH_START:   begin s.level = x;    s.first = 1'b1; end
            PH_TAIL_HI: begin s.level = 1'b1; s.first = 1'b0; end
            PH_TAIL_LO: begin s.level = 1'b0; s.first = 1'b0; end
            default:    begin s.level = 1'b0; s.first = 1'b0; end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/enc_phase_fsm.sv
module enc_phase_fsm
    import manch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x,
    output sym_t sym
);

    phase_e phase_q;
    phase_e phase_d;

    always_comb begin
        phase_d = next_phase(phase_q, x);
        sym     = symbol_of(phase_q, x);
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_START;
        else     phase_q <= phase_d;
    end

    AST_ZERO_RISES: assert property (@(posedge clk) disable iff (rst)
        (sym.first && !x) |=> (sym.level && !sym.first)); // R1
    AST_ONE_FALLS: assert property (@(posedge clk) disable iff (rst)
        (sym.first && x) |=> (!sym.level && !sym.first)); // R2
    AST_HALF_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        !sym.first |=> sym.first); // R3
    AST_RESET_TO_START: assert property (@(posedge clk)
        $fell(rst) |-> (phase_q == PH_START)); // R7

endmodule

// File: rtl/enc_out_stage.sv
module enc_out_stage
    import manch_pkg::*;
#(
    parameter bit REGISTERED = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  sym_t sym_d,
    output sym_t sym_o
);

    generate
        if (REGISTERED) begin : g_reg
            sym_t sym_q;
            always_ff @(posedge clk) begin
                if (rst) sym_q <= '0;
                else     sym_q <= sym_d;
            end
            assign sym_o = sym_q;

            AST_ONE_CYCLE_LAG: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (sym_o == $past(sym_d))); // R6
        end else begin : g_comb
            assign sym_o = sym_d;
        end
    endgenerate

endmodule

// File: rtl/nrz_manchester_enc.sv
module nrz_manchester_enc
    import manch_pkg::*;
#(
    parameter bit REGISTERED_OUT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic nrz_in,
    output logic line_out,
    output logic bit_first
);

    sym_t sym_raw;
    sym_t sym_out;

    enc_phase_fsm u_fsm (
        .clk (clk),
        .rst (rst),
        .x   (nrz_in),
        .sym (sym_raw)
    );

    enc_out_stage #(.REGISTERED(REGISTERED_OUT)) u_out (
        .clk   (clk),
        .rst   (rst),
        .sym_d (sym_raw),
        .sym_o (sym_out)
    );

    assign line_out  = sym_out.level;
    assign bit_first = sym_out.first;

endmodule

// File: tb/nrz_manchester_enc_test.sv
module nrz_manchester_enc_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nrz = 1'b0;
    logic line_m, first_m, line_r, first_r;

    always #4 clk = ~clk;

    nrz_manchester_enc #(.REGISTERED_OUT(1'b0)) uut (
        .clk(clk), .rst(rst), .nrz_in(nrz), .line_out(line_m), .bit_first(first_m));
    nrz_manchester_enc #(.REGISTERED_OUT(1'b1)) uut_reg (
        .clk(clk), .rst(rst), .nrz_in(nrz), .line_out(line_r), .bit_first(first_r));

    int checks = 0;
    int errors = 0;
    int ph = 0;
    logic held = 1'b0;
    logic exp_rl = 1'b0;
    logic exp_rf = 1'b0;
    bit just_reset = 1'b0;
    bit done = 1'b0;

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic step(logic x, logic do_rst);
        logic exp_l;
        string tag_l, tag_f, tag_r;
        @(negedge clk);
        nrz = x;
        rst = do_rst;
        #1;
        exp_l = (ph == 0) ? x : ~held;
        if (!do_rst) begin
            if (ph == 0)       tag_l = "R5";
            else if (x !== held) tag_l = "R4";
            else if (held)     tag_l = "R2";
            else               tag_l = "R1";
            tag_f = just_reset ? "R7" : "R3";
            tag_r = just_reset ? "R7" : "R6";
            chk(tag_l, "line comb", line_m, exp_l);
            chk(tag_f, "first comb", first_m, (ph == 0));
            chk(tag_r, "line reg", line_r, exp_rl);
            chk(tag_r, "first reg", first_r, exp_rf);
        end
        @(posedge clk);
        if (do_rst) begin
            ph = 0; exp_rl = 1'b0; exp_rf = 1'b0; just_reset = 1'b1;
        end else begin
            exp_rl = exp_l;
            exp_rf = (ph == 0);
            if (ph == 0) held = x;
            ph = (ph == 0) ? 1 : 0;
            just_reset = 1'b0;
        end
    endtask

    task automatic send_bit(logic b, logic flip);
        step(b, 1'b0);
        step(flip ? ~b : b, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
        // R1 R2 clean mixed bits, runs of zeros and ones
        send_bit(0, 0); send_bit(1, 0); send_bit(1, 0); send_bit(0, 0);
        send_bit(0, 0); send_bit(1, 0); send_bit(0, 0); send_bit(1, 0);
        for (int i = 0; i < 4; i++) send_bit(0, 0);
        for (int i = 0; i < 4; i++) send_bit(1, 0);
        // R4 flipped second halves
        send_bit(0, 1); send_bit(1, 1); send_bit(1, 1); send_bit(0, 1);
        // R7 reset in mid-bit
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        send_bit(1, 0); send_bit(0, 0);
        // R7 reset on a bit boundary, held two cycles
        step(1'b1, 1'b1); step(1'b1, 1'b1);
        send_bit(0, 0); send_bit(1, 1);
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 37) == 0) step(1'($urandom), 1'b1);
            else send_bit(1'($urandom), (($urandom % 4) == 0));
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R3 actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule